// File: doc/BRIEF.md
# LED Blink Generator with Auto-Stop

This block drives a single LED with a blink waveform built from a coarse tick. The tick comes from a power-of-two prescaler on the block clock. A period counter steps once per tick. The LED is lit for the first part of every period, and the duty value sets how many ticks that is. Software programs four registers through a simple word-indexed write port. All four read back on a combinational read port.

In auto-stop mode the block counts completed periods. When the programmed count is reached, it turns itself off and holds the LED dark. It also sets a sticky completion flag, which raises an interrupt unless a mask bit blocks it. Any write to the control word restarts the waveform from the start of a period and clears the completion flag. Period and duty writes made while the LED runs do not break the current period. They are picked up at the next period boundary.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset every register reads zero, and `led_o` and `irq_o` are low.
- R2: Register word index 0 is the control word, with bits [3:0] time-base select, bit 4 run, bit 5 auto-stop enable and bit 6 interrupt mask. Index 1 is the 12-bit period, index 2 the 12-bit duty and index 3 the 16-bit stop count. Each register reads back what was written, with bits above its width read as zero.
- R3: While the run bit is 0, `led_o` stays low.
- R4: With time-base select n, one tick occurs every 2^n clocks. Counting from the cycle after a control write with the run bit set, `led_o` is high for the first duty ticks of each period of period ticks and low for the rest.
- R5: A duty of 0 keeps `led_o` low while running. A duty equal to or above the period keeps it high.
- R6: A time-base select above 13 behaves exactly as 13.
- R7: A period or duty write made during a period leaves that period unchanged. The new value applies from the next period boundary.
- R8: With auto-stop on, the run bit clears at the end of the period whose completion brings the completed-period count to the stop count. From then on `led_o` is low and the run bit reads 0. A stop count of 0 behaves as 1.
- R9: Completion sets a sticky done flag. `irq_o` is high while the flag is set and the mask bit is 0, and low while the mask bit is 1. Any control write clears the flag.
- R10: With auto-stop off, the stop count has no effect and blinking continues past that many periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for one register |
| reg_addr | input | 2 | Register word index (0 control, 1 period, 2 duty, 3 stop count) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the register chosen by `reg_addr` |
| led_o | output | 1 | LED drive |
| irq_o | output | 1 | Completion interrupt |

## Verification
The in-RTL assertions check several rules on every clock cycle:
- The LED is dark whenever the run bit is clear or the done flag is set.
- The done flag is sticky until a control write, and it only rises together with the run bit clearing.
- The period counter and the active duty value move only on a tick or at a period boundary.
- With a non-zero select, ticks never arrive on back-to-back clocks.

Several behaviours can only be shown by the bench's scenarios, which compare the LED and interrupt cycle by cycle against a waveform worked out from the register values:
- The exact high and low lengths for each time base, including the clamp at 13.
- The point at which a duty change takes effect in the middle of a run.
- The period on which auto-stop fires, including a stop count of 0.
- The read-back values.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

  // Control word layout
  localparam int TB_W      = 4;
  localparam int EN_BIT    = 4;
  localparam int AUTO_BIT  = 5;
  localparam int MASK_BIT  = 6;
  localparam int CTRL_W    = 7;

  // Largest usable time-base select
  localparam int TB_MAX    = 13;

  typedef enum logic [1:0] {
    IDX_CTRL = 2'd0,
    IDX_PER  = 2'd1,
    IDX_DUTY = 2'd2,
    IDX_STOP = 2'd3
  } reg_idx_e;

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int SEL_W     = 4,
  parameter int MAX_SHIFT = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [MAX_SHIFT-1:0] pre_q, pre_d;
  logic [MAX_SHIFT-1:0] mask;
  logic [SEL_W-1:0]     sel_eff;

  // Selects above the limit are clamped
  always_comb begin
    sel_eff = (sel > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : sel;
    for (int i = 0; i < MAX_SHIFT; i++) begin
      mask[i] = (i < int'(sel_eff));
    end
  end

  assign tick = run && ((pre_q & mask) == mask);

  always_comb begin
    if (restart || !run) pre_d = '0;
    else                 pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R4: a divided time base never ticks on two consecutive clocks
  a_r4_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (sel_eff != '0) && !restart) |=> !tick);

endmodule

// File: rtl/led_wave_gen.sv
module led_wave_gen #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  input  logic [PER_W-1:0] per_reg,
  input  logic [PER_W-1:0] duty_reg,
  output logic             led,
  output logic             wrap
);

  logic [PER_W-1:0] pos_q, pos_d;
  logic [PER_W-1:0] act_per_q, act_per_d;
  logic [PER_W-1:0] act_duty_q, act_duty_d;
  logic             last;

  // A period of 0 acts as a single tick
  assign last = ({1'b0, pos_q} + 1'b1) >= {1'b0, act_per_q};
  assign wrap = run && tick && last;
  assign led  = run && (pos_q < act_duty_q);

  always_comb begin
    pos_d      = pos_q;
    act_per_d  = act_per_q;
    act_duty_d = act_duty_q;
    if (restart) begin
      pos_d      = '0;
      act_per_d  = per_reg;
      act_duty_d = duty_reg;
    end else if (run && tick) begin
      if (last) begin
        pos_d      = '0;
        act_per_d  = per_reg;
        act_duty_d = duty_reg;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= '0;
      act_per_q  <= '0;
      act_duty_q <= '0;
    end else begin
      pos_q      <= pos_d;
      act_per_q  <= act_per_d;
      act_duty_q <= act_duty_d;
    end
  end

  // R4: the position only moves on a tick or a restart
  a_r4_pos_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(pos_q));

  // R7: the active duty changes only at a boundary or a restart
  a_r7_duty_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !restart) |=> $stable(act_duty_q));

endmodule

// File: rtl/led_autostop.sv
module led_autostop #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             autostop,
  input  logic             wrap,
  input  logic [CNT_W-1:0] stop_cnt,
  output logic             stop,
  output logic             done
);

  logic [CNT_W-1:0] blinks_q, blinks_d;
  logic             done_q, done_d;
  logic [CNT_W:0]   blinks_next;

  assign blinks_next = {1'b0, blinks_q} + 1'b1;
  // A stop count of 0 is met by the first completed period
  assign stop = autostop && wrap && (blinks_next >= {1'b0, stop_cnt});
  assign done = done_q;

  always_comb begin
    blinks_d = blinks_q;
    done_d   = done_q;
    if (restart) begin
      blinks_d = '0;
      done_d   = 1'b0;
    end else begin
      if (wrap) blinks_d = blinks_next[CNT_W-1:0];
      if (stop) done_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blinks_q <= '0;
      done_q   <= 1'b0;
    end else begin
      blinks_q <= blinks_d;
      done_q   <= done_d;
    end
  end

  // R9: the done flag holds until a control write
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !restart) |=> done_q);

endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
  import led_blink_pkg::*;
#(
  parameter int PER_W  = 12,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              led_o,
  output logic              irq_o
);

  // Reset synchroniser: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Registers
  logic [TB_W-1:0]  tb_q, tb_d;
  logic             en_q, en_d;
  logic             auto_q, auto_d;
  logic             mask_q, mask_d;
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] duty_q, duty_d;
  logic [CNT_W-1:0] stop_q, stop_d;

  logic wr_ctrl, wr_per, wr_duty, wr_stop;
  logic tick, wrap, stop, done, led;

  always_comb begin
    wr_ctrl = reg_wr && (reg_idx_e'(reg_addr) == IDX_CTRL);
    wr_per  = reg_wr && (reg_idx_e'(reg_addr) == IDX_PER);
    wr_duty = reg_wr && (reg_idx_e'(reg_addr) == IDX_DUTY);
    wr_stop = reg_wr && (reg_idx_e'(reg_addr) == IDX_STOP);
  end

  always_comb begin
    tb_d   = tb_q;
    en_d   = en_q;
    auto_d = auto_q;
    mask_d = mask_q;
    per_d  = per_q;
    duty_d = duty_q;
    stop_d = stop_q;
    if (wr_ctrl) begin
      tb_d   = reg_wdata[TB_W-1:0];
      en_d   = reg_wdata[EN_BIT];
      auto_d = reg_wdata[AUTO_BIT];
      mask_d = reg_wdata[MASK_BIT];
    end else if (stop) begin
      en_d   = 1'b0;
    end
    if (wr_per)  per_d  = reg_wdata[PER_W-1:0];
    if (wr_duty) duty_d = reg_wdata[PER_W-1:0];
    if (wr_stop) stop_d = reg_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tb_q   <= '0;
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      mask_q <= 1'b0;
      per_q  <= '0;
      duty_q <= '0;
      stop_q <= '0;
    end else begin
      tb_q   <= tb_d;
      en_q   <= en_d;
      auto_q <= auto_d;
      mask_q <= mask_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      stop_q <= stop_d;
    end
  end

  // Read-back
  always_comb begin
    unique case (reg_idx_e'(reg_addr))
      IDX_CTRL: reg_rdata = DATA_W'({mask_q, auto_q, en_q, tb_q});
      IDX_PER:  reg_rdata = DATA_W'(per_q);
      IDX_DUTY: reg_rdata = DATA_W'(duty_q);
      default:  reg_rdata = DATA_W'(stop_q);
    endcase
  end

  led_tick_gen #(
    .SEL_W     (TB_W),
    .MAX_SHIFT (TB_MAX)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (wr_ctrl),
    .run     (en_q),
    .sel     (tb_q),
    .tick    (tick)
  );

  led_wave_gen #(
    .PER_W (PER_W)
  ) u_wave (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .restart  (wr_ctrl),
    .run      (en_q),
    .tick     (tick),
    .per_reg  (per_q),
    .duty_reg (duty_q),
    .led      (led),
    .wrap     (wrap)
  );

  led_autostop #(
    .CNT_W (CNT_W)
  ) u_stop (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .restart  (wr_ctrl),
    .autostop (auto_q),
    .wrap     (wrap),
    .stop_cnt (stop_q),
    .stop     (stop),
    .done     (done)
  );

  assign led_o = led;
  assign irq_o = done && !mask_q;

  // R3: no light while the run bit is clear
  a_r3_idle_dark: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_q |-> !led_o);

  // R8: completion and run-bit clearing happen on the same edge
  a_r8_stop_disables: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(done) |-> !en_q);

  // R8: the LED stays dark after completion
  a_r8_stopped_dark: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> !led_o);

endmodule

// File: tb/tb_led_blink_ctrl.sv
module tb_led_blink_ctrl;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        led_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  typedef struct {
    logic  led;
    logic  irq;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;

  led_blink_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .led_o     (led_o),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Monitor: pop one expected item per falling edge while any are queued
  always @(negedge clk) begin
    if (q.size() > 0) begin
      mon_e = q.pop_front();
      n_checks++;
      if (led_o !== mon_e.led || irq_o !== mon_e.irq) begin
        n_fails++;
        $display("FAIL %s: led=%0b irq=%0b expected led=%0b irq=%0b",
                 mon_e.tag, led_o, irq_o, mon_e.led, mon_e.irq);
      end
    end
  end

  task automatic push(input logic l, input logic i, input string t);
    exp_t e;
    e.led = l;
    e.irq = i;
    e.tag = t;
    q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(posedge clk);
    #1;
    reg_wr    = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", t, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string t);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(t, reg_rdata, exp);
  endtask

  // Expected waveform: tick every 2^n clocks, high for the first d ticks of p
  task automatic push_wave(input int n, input int p, input int d, input int cycles,
                           input string t);
    for (int j = 0; j < cycles; j++) begin
      int pos;
      pos = (j >> n) % p;
      push(pos < d, 1'b0, t);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete (got timeout, expected finish)");
      summary();
      $finish;
    end
  end

  initial begin
    reg_wr    = 1'b0;
    reg_addr  = 2'd0;
    reg_wdata = '0;
    rst_n     = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    @(negedge clk);
    chk("R1 led", {15'd0, led_o}, 16'd0);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    for (int a = 0; a < 4; a++) rd_chk(a[1:0], 16'h0000, "R1 readback");

    // R2: register read-back with upper bits cut off
    wr(2'd1, 16'hFABC);
    wr(2'd2, 16'hF123);
    wr(2'd3, 16'h0001);
    wr(2'd0, 16'hFF8F);
    rd_chk(2'd0, 16'h000F, "R2 ctrl");
    rd_chk(2'd1, 16'h0ABC, "R2 period");
    rd_chk(2'd2, 16'h0123, "R2 duty");
    rd_chk(2'd3, 16'h0001, "R2 stop");

    // R3: run bit clear keeps the LED dark
    for (int j = 0; j < 20; j++) push(1'b0, 1'b0, "R3");
    drain();

    // R4, R7, R10: n=0, period 8, duty 3 then 6 from period 1; auto-stop off
    wr(2'd1, 16'd8);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0010);
    for (int j = 0; j < 32; j++) begin
      int pos;
      pos = j % 8;
      push(pos < ((j < 8) ? 3 : 6), 1'b0, (j < 8) ? "R4" : "R7/R10");
    end
    wr(2'd2, 16'd6);
    drain();

    // R4: n=2, period 3, duty 1
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0012);
    push_wave(2, 3, 1, 48, "R4 divided");
    drain();

    // R5: duty 0 stays low, duty above period stays high
    wr(2'd1, 16'd5);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0010);
    push_wave(0, 5, 0, 20, "R5 zero duty");
    drain();
    wr(2'd2, 16'd9);
    wr(2'd0, 16'h0010);
    push_wave(0, 5, 9, 20, "R5 full duty");
    drain();

    // R6: select 15 behaves as 13
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h001F);
    push_wave(13, 2, 1, 16400, "R6 clamp");
    drain();

    // R8, R9: auto-stop after 3 periods, interrupt unmasked
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd2);
    wr(2'd3, 16'd3);
    wr(2'd0, 16'h0030);
    for (int j = 0; j < 20; j++) begin
      if (j < 12) push((j % 4) < 2, 1'b0, "R8 run");
      else        push(1'b0, 1'b1, "R8/R9 stopped");
    end
    drain();
    rd_chk(2'd0, 16'h0020, "R8 run bit cleared");
    wr(2'd0, 16'h0000);
    for (int j = 0; j < 4; j++) push(1'b0, 1'b0, "R9 cleared by write");
    drain();

    // R8, R9: stop count 0 acts as 1, interrupt masked
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd1);
    wr(2'd3, 16'd0);
    wr(2'd0, 16'h0070);
    for (int j = 0; j < 10; j++) begin
      if (j < 2) push(j < 1, 1'b0, "R8 count0");
      else       push(1'b0, 1'b0, "R9 masked");
    end
    drain();
    rd_chk(2'd0, 16'h0060, "R8 count0 run bit");

    // R9: same run unmasked raises the interrupt
    wr(2'd0, 16'h0030);
    for (int j = 0; j < 6; j++) begin
      if (j < 2) push(j < 1, 1'b0, "R9 unmasked run");
      else       push(1'b0, 1'b1, "R9 unmasked irq");
    end
    drain();

    finished = 1;
    summary();
    $finish;
  end

endmodule